// File: doc/BRIEF.md
# PHY Event Interrupt Register Block

This block holds the interrupt state of an Ethernet PHY management register file. The link-monitoring logic hands it one-cycle pulses, one per kind of event. Each pulse sets a sticky status bit. A read of the status register clears every set bit, even when interrupts are disabled, so software can still poll. The status bits, the per-event enables and a global enable combine into a single interrupt request. A test bit can force that request on for as long as it stays set.

The interrupt leaves the block on a shared active-low pin. When the output-enable control bit is set, the block drives that pin. When the bit is clear, the pin driver is switched off. The pin's incoming level is then passed on as a power-down request, with a low level asking for power-down.

Register access uses a plain port with a 5-bit address, separate read and write strobes, and 16-bit data. Read data is combinational in the cycle the read strobe is high. A write or a read-clear takes effect at the next rising clock edge.

Top module: `phy_irq_regs`

## Requirements
- R1: After reset, both registers read as zero. The pin driver is disabled (`irq_pin_oe_o`=0) and `irq_pin_n_o` is 1.
- R2: The control register is at address 0x11. Bit 2 is the test-force bit, bit 1 is the global event enable and bit 0 is the pin output enable. Writes to bits 15:3 are ignored and those bits read as 0.
- R3: The status register is at address 0x12. Event input bit i sets status bit 10+i in the cycle after its pulse, whether or not its enable is set. The mapping is: bit 15 link quality (event 5), bit 14 energy detect (event 4), bit 13 link change (event 3), bit 12 speed change (event 2), bit 11 duplex change (event 1) and bit 10 auto-negotiation done (event 0).
- R4: A read of address 0x12 returns the current contents and clears every set status bit at that clock edge.
- R5: An event that arrives in the same cycle as a status read is kept set after the read. The data returned by that read does not include it.
- R6: A write to 0x12 loads the enables from bits 5:0, where bit i enables event i. The write leaves the status bits unchanged. Bits 9:6 ignore writes and read as 0.
- R7: The event interrupt is active only when the global enable is 1 and at least one status bit has its enable set.
- R8: While the test-force bit is 1, the interrupt is active whatever the events are. It goes inactive once the bit is cleared and no event interrupt remains.
- R9: With output enable at 1, `irq_pin_oe_o` is 1, `irq_pin_n_o` is low while the interrupt is active, and `pwrdn_req_o` is 0.
- R10: With output enable at 0, `irq_pin_oe_o` is 0 and `pwrdn_req_o` equals the inverse of `irq_pin_i`.
- R11: A read of any other address returns 0. Reading 0x11 does not clear any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | One-cycle event pulses; bit i is event i |
| reg_addr_i | input | 5 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while `reg_rd_i` is high |
| irq_pin_i | input | 1 | Level seen on the shared pin |
| irq_pin_n_o | output | 1 | Active-low interrupt value for the pin |
| irq_pin_oe_o | output | 1 | Pin driver enable |
| pwrdn_req_o | output | 1 | Power-down request taken from the pin |

## Verification
The bench builds the block with its default of six event sources, 16-bit data and 5-bit addresses. With this layout the status field fills bits 15:10, the enable field fills bits 5:0, and bits 9:6 are a reserved gap that the bench can observe. Six sources let the bench mark events as enabled or disabled independently. It can therefore check that a pending but disabled event raises no interrupt while an enabled neighbour does. It also checks that an event landing on the read cycle survives the clear.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h11;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'h12;
    localparam int CTRL_OE_BIT   = 0;
    localparam int CTRL_GEN_BIT  = 1;
    localparam int CTRL_TEST_BIT = 2;

    typedef struct packed {
        logic test;
        logic gen;
        logic oe;
    } ctrl_t;
endpackage

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phy_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  ctrl_t wval_i,
    output ctrl_t ctrl_o
);
    typedef struct packed {
        ctrl_t c;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.c = wval_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.c;

    // R2: a write loads the three control bits
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ctrl_o == $past(wval_i));
endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status #(
    parameter int NUM_EVENTS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic                  rd_clr_i,
    input  logic                  wr_i,
    input  logic [NUM_EVENTS-1:0] wen_i,
    output logic [NUM_EVENTS-1:0] stat_o,
    output logic [NUM_EVENTS-1:0] en_o
);
    typedef struct packed {
        logic [NUM_EVENTS-1:0] stat;
        logic [NUM_EVENTS-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // clear on read, but a coincident event wins
        st_d.stat = (rd_clr_i ? '0 : st_q.stat) | evt_i;
        if (wr_i) st_d.en = wen_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;

    // R3 / R5: every pulsed event is latched, even on a read cycle
    p_evt_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

    // R4: a read with no new event empties the status field
    p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && evt_i == '0) |=> stat_o == '0);

    // R6: enable write takes the new value
    p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> en_o == $past(wen_i));

    // R6: a write alone never drops a pending status bit
    p_stat_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_clr_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
endmodule

// File: rtl/phy_irq_pin.sv
module phy_irq_pin
    import phy_irq_pkg::*;
#(
    parameter int NUM_EVENTS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ctrl_t                 ctrl_i,
    input  logic [NUM_EVENTS-1:0] stat_i,
    input  logic [NUM_EVENTS-1:0] en_i,
    input  logic                  pin_i,
    output logic                  pin_n_o,
    output logic                  pin_oe_o,
    output logic                  pwrdn_req_o
);
    logic evt_irq;
    logic irq_active;

    assign evt_irq     = ctrl_i.gen && ((stat_i & en_i) != '0);
    assign irq_active  = ctrl_i.test || evt_irq;
    assign pin_n_o     = ~irq_active;
    assign pin_oe_o    = ctrl_i.oe;
    assign pwrdn_req_o = ctrl_i.oe ? 1'b0 : ~pin_i;

    // R8: test bit forces the pin low
    p_test_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.test |-> !pin_n_o);

    // R7: no global enable and no test means no interrupt
    p_gen_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.gen && !ctrl_i.test) |-> pin_n_o);

    // R9: driving the pin suppresses the power-down request
    p_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.oe |-> (pin_oe_o && !pwrdn_req_o));

    // R10: input mode releases the pin
    p_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.oe |-> (!pin_oe_o && pwrdn_req_o == !pin_i));
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_irq_pkg::*;
#(
    parameter int NUM_EVENTS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_rd_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  irq_pin_i,
    output logic                  irq_pin_n_o,
    output logic                  irq_pin_oe_o,
    output logic                  pwrdn_req_o
);
    localparam int STAT_LSB = DATA_W - NUM_EVENTS;

    logic                  sel_ctrl, sel_stat;
    logic                  wr_ctrl, wr_stat, rd_stat;
    ctrl_t                 ctrl_wval, ctrl_q;
    logic [NUM_EVENTS-1:0] stat, en;
    logic                  unused_wdata;

    assign sel_ctrl = (reg_addr_i == ADDR_CTRL);
    assign sel_stat = (reg_addr_i == ADDR_STAT);
    assign wr_ctrl  = reg_wr_i && sel_ctrl;
    assign wr_stat  = reg_wr_i && sel_stat;
    assign rd_stat  = reg_rd_i && sel_stat;

    assign ctrl_wval.test = reg_wdata_i[CTRL_TEST_BIT];
    assign ctrl_wval.gen  = reg_wdata_i[CTRL_GEN_BIT];
    assign ctrl_wval.oe   = reg_wdata_i[CTRL_OE_BIT];
    assign unused_wdata   = &{1'b0, reg_wdata_i[DATA_W-1:NUM_EVENTS]};

    phy_irq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_ctrl),
        .wval_i (ctrl_wval),
        .ctrl_o (ctrl_q)
    );

    phy_irq_status #(.NUM_EVENTS(NUM_EVENTS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .rd_clr_i (rd_stat),
        .wr_i     (wr_stat),
        .wen_i    (reg_wdata_i[NUM_EVENTS-1:0]),
        .stat_o   (stat),
        .en_o     (en)
    );

    phy_irq_pin #(.NUM_EVENTS(NUM_EVENTS)) u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl_q),
        .stat_i      (stat),
        .en_i        (en),
        .pin_i       (irq_pin_i),
        .pin_n_o     (irq_pin_n_o),
        .pin_oe_o    (irq_pin_oe_o),
        .pwrdn_req_o (pwrdn_req_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i && sel_ctrl) begin
            reg_rdata_o[CTRL_TEST_BIT] = ctrl_q.test;
            reg_rdata_o[CTRL_GEN_BIT]  = ctrl_q.gen;
            reg_rdata_o[CTRL_OE_BIT]   = ctrl_q.oe;
        end else if (rd_stat) begin
            reg_rdata_o[DATA_W-1:STAT_LSB] = stat;
            reg_rdata_o[NUM_EVENTS-1:0]    = en;
        end
    end

    // R2: reserved control bits always read as zero
    p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && sel_ctrl) |-> reg_rdata_o[DATA_W-1:CTRL_TEST_BIT+1] == '0);

    // R11: reading the control register leaves status intact
    p_ctrl_read_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && sel_ctrl) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: tb/phy_irq_regs_tb.sv
module phy_irq_regs_tb;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pin_in = 1'b1;
    logic        irq_n, pin_oe, pwrdn;

    int n_checks = 0;
    int n_fail   = 0;

    string       req_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];

    always #4 clk = ~clk;

    phy_irq_regs #(.NUM_EVENTS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_pin_i(pin_in), .irq_pin_n_o(irq_n),
        .irq_pin_oe_o(pin_oe), .pwrdn_req_o(pwrdn)
    );

    // driver side: push expectation and observed value
    task automatic expect_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        req_q.push_back(req);
        exp_q.push_back(exp);
        act_q.push_back(act);
    endtask

    // monitor: pop and compare
    task automatic drain();
        while (exp_q.size() > 0) begin
            string r = req_q.pop_front();
            logic [15:0] e = exp_q.pop_front();
            logic [15:0] a = act_q.pop_front();
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", r, a, e);
            end
        end
    endtask

    initial forever begin
        @(posedge clk);
        drain();
    end

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        #1;
    endtask

    task automatic do_read(input logic [4:0] a, input logic [N-1:0] ev, output logic [15:0] v);
        addr = a; rd = 1'b1; evt = ev;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        #1;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
        #1;
    endtask

    function automatic logic [15:0] sb(input logic [N-1:0] m);
        return {m, 10'b0};
    endfunction

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        expect_val("R1 irq_n", {15'b0, irq_n}, 16'h1);
        expect_val("R1 pin_oe", {15'b0, pin_oe}, 16'h0);
        do_read(5'h11, '0, v); expect_val("R1 ctrl", v, 16'h0000);
        do_read(5'h12, '0, v); expect_val("R1 status", v, 16'h0000);
        expect_val("R10 pwrdn pin high", {15'b0, pwrdn}, 16'h0);
        pin_in = 1'b0; #1;
        expect_val("R10 pwrdn pin low", {15'b0, pwrdn}, 16'h1);

        // R2 reserved, R8 test force, R9 drive
        do_write(5'h11, 16'hFFFF);
        do_read(5'h11, '0, v); expect_val("R2 ctrl rsvd", v, 16'h0007);
        expect_val("R8 forced", {15'b0, irq_n}, 16'h0);
        expect_val("R9 oe", {15'b0, pin_oe}, 16'h1);
        expect_val("R9 pwrdn off", {15'b0, pwrdn}, 16'h0);
        do_write(5'h11, 16'h0001);
        expect_val("R8 released", {15'b0, irq_n}, 16'h1);

        // R3 latch while disabled, R4 clear
        pulse(6'b100000);
        expect_val("R7 disabled evt", {15'b0, irq_n}, 16'h1);
        do_read(5'h12, '0, v); expect_val("R3 link quality", v, 16'h8000);
        do_read(5'h12, '0, v); expect_val("R4 cleared", v, 16'h0000);

        // R6 enable write keeps status
        pulse(6'b000011);
        do_write(5'h12, 16'hFFFF);
        expect_val("R7 no global", {15'b0, irq_n}, 16'h1);
        do_write(5'h11, 16'h0003);
        expect_val("R7 active", {15'b0, irq_n}, 16'h0);
        do_read(5'h12, '0, v); expect_val("R6 status kept", v, sb(6'b000011) | 16'h003F);
        expect_val("R4 irq after clear", {15'b0, irq_n}, 16'h1);
        do_read(5'h12, '0, v); expect_val("R4 empty", v, 16'h003F);

        // R5 coincident event
        do_read(5'h12, 6'b000100, v); expect_val("R5 pre-clear data", v, 16'h003F);
        expect_val("R5 irq kept", {15'b0, irq_n}, 16'h0);
        do_read(5'h12, '0, v); expect_val("R5 kept bit", v, sb(6'b000100) | 16'h003F);

        // R11 other address, ctrl read no clear
        pulse(6'b001000);
        do_read(5'h00, '0, v); expect_val("R11 other addr", v, 16'h0000);
        do_read(5'h11, '0, v); expect_val("R11 ctrl read", v, 16'h0003);
        do_read(5'h12, '0, v); expect_val("R11 status kept", v, sb(6'b001000) | 16'h003F);

        // R7 enable subset
        do_write(5'h12, 16'h0004);
        pulse(6'b001000);
        expect_val("R7 masked evt", {15'b0, irq_n}, 16'h1);
        do_read(5'h12, '0, v); expect_val("R7 masked status", v, sb(6'b001000) | 16'h0004);
        pulse(6'b000100);
        expect_val("R7 enabled evt", {15'b0, irq_n}, 16'h0);
        do_read(5'h12, '0, v); expect_val("R7 enabled status", v, sb(6'b000100) | 16'h0004);
        expect_val("R7 after clear", {15'b0, irq_n}, 16'h1);

        // R10 input mode
        do_write(5'h11, 16'h0002);
        pulse(6'b000100);
        expect_val("R10 tristate", {15'b0, pin_oe}, 16'h0);
        pin_in = 1'b0; #1;
        expect_val("R10 pwrdn low", {15'b0, pwrdn}, 16'h1);
        pin_in = 1'b1; #1;
        expect_val("R10 pwrdn high", {15'b0, pwrdn}, 16'h0);

        @(negedge clk);
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        drain();
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule